// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight device request lines and presents one interrupt request to a processor. When the processor acknowledges, the controller drives an 8-bit vector onto a data bus for one cycle. The vector is a programmable base plus the number of the winning line. Each line can be masked on its own, and each can sense either a rising edge or a high level. Line 0 has the highest priority and line 7 the lowest.

An in-service register records every line that has been acknowledged and not yet retired. No request is raised unless a pending unmasked line outranks the highest-priority line in service. Software retires an interrupt with an end-of-interrupt write, which frees the highest-priority in-service line. The same small register port also sets the mask, the trigger modes and the vector base.

Requests are registered once on entry. A level line therefore reaches the request output one clock after it is sampled. An edge line needs one further clock to latch.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, intReq and vecValid are low, all lines are masked, all lines are in edge mode, and the vector base is 0x20.
- R2: A cycle with cfgWrEn high performs the write chosen by cfgSel: 0 writes the mask (bit i = 1 masks line i), 1 writes the trigger modes (bit i = 1 selects level sensing for line i), 2 writes the vector base, and 3 is an end-of-interrupt (cfgData is ignored).
- R3: A line in edge mode becomes pending on a rising edge of its input. It stays pending after the input falls, until that line is acknowledged.
- R4: A line in level mode is pending only while its input is high. If the input drops before acknowledge, the request is withdrawn.
- R5: A masked line never raises intReq and is never granted. A rising edge seen while the line is masked is held, and it raises intReq once the line is unmasked.
- R6: Among the pending unmasked lines, the lowest-numbered line wins.
- R7: A one-cycle intAck while intReq is high makes vecValid high for exactly the next cycle, with vecOut equal to the base plus the winning line number. The same acknowledge clears that line's edge latch and sets its in-service bit.
- R8: intReq is low unless some pending unmasked line has a lower number than every line in service. This holds for a level line still high after its own acknowledge.
- R9: An end-of-interrupt clears only the lowest-numbered in-service bit.
- R10: A base write below 0x20 is ignored. On an accepted base write, the low three bits are forced to zero, so vectors never wrap and never fall below 0x20.
- R11: An intAck while intReq is low produces no vecValid pulse and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| devReq | input | 8 | Device request lines, one per source |
| cfgWrEn | input | 1 | Register port write strobe |
| cfgSel | input | 2 | Write target: mask, mode, base, end-of-interrupt |
| cfgData | input | 8 | Write data |
| intAck | input | 1 | Processor acknowledge, one-cycle pulse |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector of the acknowledged line |
| vecValid | output | 1 | High for the cycle in which vecOut is fresh |

## Verification
The tests drive the following request patterns:
- A single edge pulse that falls before acknowledge, which shows the latch holds the request.
- A level line that drops early and later stays high across its own service, which separates live sensing from latching and shows the in-service block.
- Two simultaneous edges, which check the priority order.
- A low-priority request preempted by a higher one, which shows that end-of-interrupt retires the right bit: a middle-priority line is raised afterwards and is only visible if exactly the top bit was freed.
- A masked edge that is later released.

Base writes above and below the floor, and an acknowledge with nothing pending, complete the set.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  parameter int unsigned IRQ_LINES = 8;
  parameter int unsigned IDX_W = $clog2(IRQ_LINES);

  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_MODE = 2'd1,
    CFG_BASE = 2'd2,
    CFG_EOI  = 2'd3
  } cfgSel_e;

  typedef struct packed {
    logic                 grant;
    logic [IRQ_LINES-1:0] grantOh;
    logic [IDX_W-1:0]     grantIdx;
    logic                 eoi;
    logic [IRQ_LINES-1:0] eoiOh;
    logic                 wrMask;
    logic                 wrMode;
    logic                 wrBase;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_vec_prio.sv
module irq_vec_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  oh
);
  // lowest set bit wins
  always_comb begin
    found = |vec;
    oh    = vec & (~vec + N'(1));
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_vec_control.sv
module irq_vec_control
  import irq_vec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_LINES-1:0] effPend,
  input  logic [IRQ_LINES-1:0] inService,
  input  logic                 intAck,
  input  logic                 cfgWrEn,
  input  logic [1:0]           cfgSel,
  output logic                 intReq,
  output ctrlStrobe_t          st
);
  logic                 candFound, isrFound;
  logic [IDX_W-1:0]     candIdx, isrIdx;
  logic [IRQ_LINES-1:0] candOh, isrOh;
  logic                 outrank;
  cfgSel_e              selE;

  irq_vec_prio #(.N(IRQ_LINES)) uCand (
    .vec(effPend), .found(candFound), .idx(candIdx), .oh(candOh)
  );
  irq_vec_prio #(.N(IRQ_LINES)) uIsr (
    .vec(inService), .found(isrFound), .idx(isrIdx), .oh(isrOh)
  );

  assign selE    = cfgSel_e'(cfgSel);
  assign outrank = candFound && (!isrFound || (candIdx < isrIdx));
  assign intReq  = outrank;

  always_comb begin
    st          = '0;
    st.grant    = intAck && outrank;
    st.grantOh  = st.grant ? candOh : '0;
    st.grantIdx = candIdx;
    st.eoi      = cfgWrEn && (selE == CFG_EOI);
    st.eoiOh    = st.eoi ? isrOh : '0;
    st.wrMask   = cfgWrEn && (selE == CFG_MASK);
    st.wrMode   = cfgWrEn && (selE == CFG_MODE);
    st.wrBase   = cfgWrEn && (selE == CFG_BASE);
  end

  // R6: at most one line granted, and no lower-numbered line left pending
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.grantOh));
  p_grant_lowest_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.grant |-> ((effPend & (st.grantOh - IRQ_LINES'(1))) == '0));
  // R8: a granted line is never already in service
  p_grant_not_isr_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.grant |-> ((st.grantOh & inService) == '0));
endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned RSV_LIMIT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_LINES-1:0] devReq,
  input  logic [VEC_W-1:0]     cfgData,
  input  ctrlStrobe_t          st,
  output logic [IRQ_LINES-1:0] effPend,
  output logic [IRQ_LINES-1:0] inService,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  localparam logic [VEC_W-1:0] FLOOR = VEC_W'(RSV_LIMIT);
  localparam logic [VEC_W-1:0] BASE_RST = {FLOOR[VEC_W-1:IDX_W], {IDX_W{1'b0}}};

  logic [IRQ_LINES-1:0] reqQ, reqPrev, rise, edgePend, maskQ, modeQ, isr;
  logic [VEC_W-1:0]     baseQ;

  assign rise      = reqQ & ~reqPrev;
  assign inService = isr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= '0;
      reqPrev <= '0;
    end else begin
      reqQ    <= devReq;
      reqPrev <= reqQ;
    end
  end

  for (genvar g = 0; g < IRQ_LINES; g++) begin : gLine
    assign effPend[g] = (modeQ[g] ? reqQ[g] : edgePend[g]) & ~maskQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) edgePend[g] <= 1'b0;
      else if (modeQ[g]) edgePend[g] <= 1'b0;
      else if (rise[g]) edgePend[g] <= 1'b1;
      else if (st.grantOh[g]) edgePend[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '1;
      modeQ    <= '0;
      baseQ    <= BASE_RST;
      isr      <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      if (st.wrMask) maskQ <= cfgData[IRQ_LINES-1:0];
      if (st.wrMode) modeQ <= cfgData[IRQ_LINES-1:0];
      if (st.wrBase && (cfgData >= FLOOR))
        baseQ <= {cfgData[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
      isr      <= (isr & ~st.eoiOh) | st.grantOh;
      vecValid <= st.grant;
      if (st.grant) vecOut <= baseQ + VEC_W'(st.grantIdx);
    end
  end

  // R10: every delivered vector sits at or above the reserved range
  p_vec_floor_r10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecOut >= FLOOR));
  // R7: the granted line is in service on the next cycle
  p_isr_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.grant |=> ((isr & $past(st.grantOh)) != '0));
  // R5: a masked line is never granted
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.grant |-> ((st.grantOh & maskQ) == '0));
  // R9: end-of-interrupt retires exactly one in-service bit
  p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoi && !st.grant && (isr != '0)) |=>
      ($countones(isr) + 1 == $countones($past(isr))));
  // R11: no vector pulse without a grant
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rstN)
    !st.grant |=> !vecValid);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned RSV_LIMIT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_LINES-1:0] devReq,
  input  logic                 cfgWrEn,
  input  logic [1:0]           cfgSel,
  input  logic [VEC_W-1:0]     cfgData,
  input  logic                 intAck,
  output logic                 intReq,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  ctrlStrobe_t          st;
  logic [IRQ_LINES-1:0] effPend, inService;

  irq_vec_control uCtrl (
    .clk(clk), .rstN(rstN), .effPend(effPend), .inService(inService),
    .intAck(intAck), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .intReq(intReq), .st(st)
  );

  irq_vec_datapath #(.VEC_W(VEC_W), .RSV_LIMIT(RSV_LIMIT)) uData (
    .clk(clk), .rstN(rstN), .devReq(devReq), .cfgData(cfgData), .st(st),
    .effPend(effPend), .inService(inService), .vecOut(vecOut),
    .vecValid(vecValid)
  );
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] devReq = '0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [7:0] cfgData = '0;
  logic       intAck = 1'b0;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk(clk), .rstN(rstN), .devReq(devReq), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .intAck(intAck),
    .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseLine(input int line);
    @(negedge clk);
    devReq[line] = 1'b1;
    @(negedge clk);
    devReq[line] = 1'b0;
    waitCyc(2);
  endtask

  task automatic ackExpect(input logic [7:0] vec, input string tag);
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
    check({7'd0, vecValid}, 8'd1, {tag, " vecValid"});
    check(vecOut, vec, {tag, " vector"});
    @(negedge clk);
    check({7'd0, vecValid}, 8'd0, "R7 vecValid single cycle");
  endtask

  task automatic checkReq(input logic exp, input string tag);
    check({7'd0, intReq}, {7'd0, exp}, tag);
  endtask

  task automatic testReset();
    check({7'd0, intReq}, 8'd0, "R1 intReq after reset");
    check({7'd0, vecValid}, 8'd0, "R1 vecValid after reset");
    pulseLine(0);
    checkReq(1'b0, "R1 all lines masked at reset");
  endtask

  task automatic testEdge();
    cfgWrite(2'd0, 8'h01);       // R2 mask write: keep line 0 masked
    cfgWrite(2'd1, 8'h00);
    pulseLine(3);
    checkReq(1'b1, "R3 edge held after input falls");
    ackExpect(8'h23, "R1 R7 default base vector");
    checkReq(1'b0, "R7 pending cleared on ack");
    cfgWrite(2'd3, 8'h00);
    waitCyc(1);
    checkReq(1'b0, "R3 edge not re-raised after service");
  endtask

  task automatic testMaskRelease();
    cfgWrite(2'd0, 8'h00);
    waitCyc(1);
    checkReq(1'b1, "R5 held masked edge raised on unmask");
    ackExpect(8'h20, "R5 released line vector");
    cfgWrite(2'd3, 8'h00);
  endtask

  task automatic testLevel();
    cfgWrite(2'd1, 8'h10);       // R2 mode write: line 4 level
    @(negedge clk); devReq[4] = 1'b1;
    waitCyc(2);
    checkReq(1'b1, "R4 level high requests");
    devReq[4] = 1'b0;
    waitCyc(2);
    checkReq(1'b0, "R4 level withdrawn when low");
    devReq[4] = 1'b1;
    waitCyc(2);
    ackExpect(8'h24, "R4 level vector");
    checkReq(1'b0, "R8 level line blocked by own service");
    cfgWrite(2'd3, 8'h00);
    waitCyc(1);
    checkReq(1'b1, "R9 level re-raised after eoi");
    ackExpect(8'h24, "R4 level second vector");
    devReq[4] = 1'b0;
    cfgWrite(2'd3, 8'h00);
    cfgWrite(2'd1, 8'h00);
    waitCyc(2);
    checkReq(1'b0, "R4 idle after level drop");
  endtask

  task automatic testPriority();
    @(negedge clk); devReq = 8'h44;
    @(negedge clk); devReq = 8'h00;
    waitCyc(2);
    ackExpect(8'h22, "R6 lowest line wins");
    checkReq(1'b0, "R8 lower priority blocked");
    cfgWrite(2'd3, 8'h00);
    waitCyc(1);
    checkReq(1'b1, "R8 lower priority after eoi");
    ackExpect(8'h26, "R6 second line vector");
    cfgWrite(2'd3, 8'h00);
  endtask

  task automatic testNested();
    pulseLine(5);
    ackExpect(8'h25, "R7 line 5 vector");
    pulseLine(1);
    checkReq(1'b1, "R8 higher line preempts");
    ackExpect(8'h21, "R8 nested vector");
    cfgWrite(2'd3, 8'h00);
    waitCyc(1);
    checkReq(1'b0, "R9 eoi leaves line 5 in service");
    pulseLine(6);
    checkReq(1'b0, "R8 line 6 blocked by line 5");
    pulseLine(3);
    checkReq(1'b1, "R9 eoi freed only line 1");
    ackExpect(8'h23, "R9 line 3 vector");
    cfgWrite(2'd3, 8'h00);
    cfgWrite(2'd3, 8'h00);
    waitCyc(1);
    ackExpect(8'h26, "R9 line 6 after both retired");
    cfgWrite(2'd3, 8'h00);
  endtask

  task automatic testBase();
    cfgWrite(2'd2, 8'h10);
    pulseLine(2);
    ackExpect(8'h22, "R10 low base ignored");
    cfgWrite(2'd3, 8'h00);
    cfgWrite(2'd2, 8'h47);
    pulseLine(2);
    ackExpect(8'h42, "R10 base aligned");
    cfgWrite(2'd3, 8'h00);
    cfgWrite(2'd2, 8'hF8);
    pulseLine(7);
    ackExpect(8'hFF, "R10 top base no wrap");
    cfgWrite(2'd3, 8'h00);
  endtask

  task automatic testSpurious();
    waitCyc(1);
    checkReq(1'b0, "R11 idle before ack");
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
    check({7'd0, vecValid}, 8'd0, "R11 no vector without request");
    pulseLine(4);
    checkReq(1'b1, "R11 state unchanged by stray ack");
    ackExpect(8'hFC, "R11 following vector");
    cfgWrite(2'd3, 8'h00);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testEdge();
    testMaskRelease();
    testLevel();
    testPriority();
    testNested();
    testBase();
    testSpurious();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule